// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the timing strobes for a serial transmitter and receiver from a free-running count clock. A down counter divides the count clock by an 8-bit reload value plus one. Each time it runs out, it emits a one-cycle sample strobe, and sixteen of those strobes make up one bit period. A 4-bit trim value adds up to fifteen extra count-clock cycles to each bit period. This lets the bit rate fall between the coarse steps of the integer divider: rate = f_count / ((reload + 1) × 16 + trim).

The extra cycles are spread one per sample slot. The first `trim` slots of every bit period are each one cycle longer. The bit strobe is raised together with the sample strobe that closes the sixteenth slot. When the enable input is low, the divider is held loaded and the slot index is held at zero, so the first strobes after enable arrive at a known distance. The reload and trim inputs are read each time the divider reloads. A change therefore never shortens or stretches the slot that is already running.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted and on the first cycles after it, both `sample_tick` and `bit_tick` are low.
- R2: With `trim_i` = 0 and a steady `reload_i`, consecutive `sample_tick` pulses are exactly `reload_i` + 1 cycles apart.
- R3: With `trim_i` = F, sample slot k of a bit period (k = 0..15, counted from the slot after a bit strobe, or after enable) lasts `reload_i` + 2 cycles for k < F and `reload_i` + 1 cycles otherwise.
- R4: `bit_tick` is high only together with a `sample_tick`, and exactly on the one that closes slot 15.
- R5: Consecutive `bit_tick` pulses are (`reload_i` + 1) × 16 + `trim_i` cycles apart.
- R6: While `enable_i` is low, no strobes are produced after the first cycle, and the slot index returns to 0. The first `sample_tick` then appears `reload_i` + 1 + (`trim_i` ≠ 0) rising edges after the first edge at which `enable_i` is high (the tick is visible after that edge).
- R7: A change of `reload_i` or `trim_i` in the middle of a slot does not alter that slot's length. It applies from the next reload on.
- R8: With `reload_i` = 0 and `trim_i` = 0, `sample_tick` is high on every cycle and `bit_tick` is high on every sixteenth cycle.
- R9: At full scale (`reload_i` = 255, `trim_i` = 15), slots last 257 or 256 cycles and a bit period lasts 4111 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the divider; low holds it loaded and resets the slot index |
| reload_i | input | 8 | Divider reload value; each slot lasts reload + 1 cycles before trim |
| trim_i | input | 4 | Extra cycles per bit period, one added to each of the first trim slots |
| sample_tick | output | 1 | One-cycle strobe at 16 times the bit rate |
| bit_tick | output | 1 | One-cycle strobe once per bit period |

## Verification
The bench measures the distance between every pair of strobes and checks it against the slot formula. A design that adds the extra cycles to the wrong slots, or to all of them, shows one slot with the wrong length. A design that counts to fifteen or seventeen moves the bit strobe off the slot-15 boundary. Further cases are divider settings of zero and full scale: an off-by-one in the underflow test shows up at once with a reload of zero, and a narrow counter wraps at 255 plus trim. The bench also restarts after a disable, to catch a slot index that is not cleared. Finally, it changes the reload value in the middle of a slot, to catch a divider that picks up new settings before the reload.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

    localparam int DEF_RELOAD_W = 8;
    localparam int DEF_TRIM_W   = 4;
    localparam int DEF_SAMPLES  = 16;

    typedef struct packed {
        logic sample;
        logic bitp;
    } strobe_t;

endpackage

// File: rtl/baudgen_divider.sv
module baudgen_divider #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             underflow_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    assign underflow_o = enable_i && (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (!enable_i || underflow_o) begin
            st_d.cnt = load_val_i;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/baudgen_slot_ctr.sv
module baudgen_slot_ctr #(
    parameter int SAMPLES = 16,
    localparam int SLOT_W = $clog2(SAMPLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              advance_i,
    output logic [SLOT_W-1:0] slot_next_o,
    output logic              wrap_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SAMPLES - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } slot_state_t;

    slot_state_t st_d, st_q;

    assign wrap_o      = advance_i && (st_q.slot == LAST_SLOT);
    assign slot_next_o = st_d.slot;

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d.slot = '0;
        end else if (advance_i) begin
            st_d.slot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baudgen_pkg::*;
#(
    parameter int RELOAD_W = DEF_RELOAD_W,
    parameter int TRIM_W   = DEF_TRIM_W,
    parameter int SAMPLES  = DEF_SAMPLES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic [RELOAD_W-1:0] reload_i,
    input  logic [TRIM_W-1:0]   trim_i,
    output logic                sample_tick,
    output logic                bit_tick
);

    localparam int CNT_W  = RELOAD_W + 1;
    localparam int SLOT_W = $clog2(SAMPLES);

    logic              underflow;
    logic              wrap;
    logic [SLOT_W-1:0] slot_next;
    logic              extra;
    logic [CNT_W-1:0]  load_val;

    strobe_t out_d, out_q;

    // the slot about to be loaded gets one extra cycle if it is among the first trim slots
    assign extra    = int'(slot_next) < int'(trim_i);
    assign load_val = CNT_W'(reload_i) + CNT_W'(extra);

    baudgen_divider #(
        .CNT_W (CNT_W)
    ) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .load_val_i  (load_val),
        .underflow_o (underflow)
    );

    baudgen_slot_ctr #(
        .SAMPLES (SAMPLES)
    ) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .advance_i   (underflow),
        .slot_next_o (slot_next),
        .wrap_o      (wrap)
    );

    always_comb begin
        out_d        = '0;
        out_d.sample = underflow;
        out_d.bitp   = wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sample_tick = out_q.sample;
    assign bit_tick    = out_q.bitp;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
    parameter int RELOAD_W = 8,
    parameter int TRIM_W   = 4,
    parameter int SAMPLES  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable_i,
    input logic [RELOAD_W-1:0] reload_i,
    input logic [TRIM_W-1:0]   trim_i,
    input logic                sample_tick,
    input logic                bit_tick
);

    localparam int GAP_W = RELOAD_W + 4;
    localparam int SC_W  = $clog2(SAMPLES) + 1;

    logic [GAP_W-1:0]    gap_q;
    logic                seen_q;
    logic [1:0]          dirty_q;
    logic [SC_W-1:0]     scount_q;
    logic [RELOAD_W-1:0] rl_prev_q;
    logic [TRIM_W-1:0]   tr_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q     <= '0;
            seen_q    <= 1'b0;
            dirty_q   <= 2'd2;
            scount_q  <= '0;
            rl_prev_q <= '0;
            tr_prev_q <= '0;
        end else begin
            rl_prev_q <= reload_i;
            tr_prev_q <= trim_i;
            if (sample_tick) begin
                gap_q  <= GAP_W'(1);
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1'b1;
            end
            if (!enable_i || reload_i != rl_prev_q || trim_i != tr_prev_q) begin
                dirty_q <= 2'd2;
            end else if (sample_tick && dirty_q != 2'd0) begin
                dirty_q <= dirty_q - 1'b1;
            end
            if (!enable_i) begin
                scount_q <= '0;
            end else if (sample_tick) begin
                scount_q <= bit_tick ? '0 : scount_q + 1'b1;
            end
        end
    end

    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !sample_tick && !bit_tick);

    p_bit_with_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

    p_bit_on_slot15_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && enable_i |-> scount_q == SC_W'(SAMPLES - 1));

    p_slot_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick && enable_i && seen_q && dirty_q == 2'd0 |->
            (gap_q == GAP_W'(reload_i) + GAP_W'(1)) ||
            (trim_i != '0 && gap_q == GAP_W'(reload_i) + GAP_W'(2)));

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !sample_tick && !bit_tick);

endmodule

bind baud_tick_gen baud_tick_gen_chk #(
    .RELOAD_W (RELOAD_W),
    .TRIM_W   (TRIM_W),
    .SAMPLES  (SAMPLES)
) u_chk (.*);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0;
    logic [7:0] reload_i = 8'd0;
    logic [3:0] trim_i = 4'd0;
    logic       sample_tick;
    logic       bit_tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    baud_tick_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .reload_i    (reload_i),
        .trim_i      (trim_i),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1: strobes low in and right after reset
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!sample_tick && !bit_tick, "R1", int'({sample_tick, bit_tick}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sample_tick && !bit_tick, "R1", int'({sample_tick, bit_tick}), 0);
    endtask

    // measure two bit periods from enable; tag names the slot-length requirement
    task automatic t_pattern(input int rl, input int tr, input string tag);
        int t, i, prev, nbt, bt_prev, exp;
        @(negedge clk);
        enable_i = 1'b0;
        reload_i = 8'(rl);
        trim_i   = 4'(tr);
        repeat (3) @(negedge clk);
        enable_i = 1'b1;
        t = 0; i = 0; prev = 0; nbt = 0; bt_prev = 0;
        while (nbt < 2 && t < 20000) begin
            @(posedge clk);
            #1;
            t++;
            if (sample_tick) begin
                exp = rl + 1 + (((i % 16) < tr) ? 1 : 0);
                if (i == 0) chk(t == exp, "R6", t, exp);
                else        chk(t - prev == exp, tag, t - prev, exp);
                chk(bit_tick == ((i % 16) == 15), "R4", int'(bit_tick), int'((i % 16) == 15));
                if (bit_tick) begin
                    nbt++;
                    if (nbt == 2) chk(t - bt_prev == (rl + 1) * 16 + tr, "R5",
                                      t - bt_prev, (rl + 1) * 16 + tr);
                    bt_prev = t;
                end
                prev = t;
                i++;
            end else if (bit_tick) begin
                chk(1'b0, "R4", 1, 0);
            end
        end
        chk(nbt == 2, "R5", nbt, 2);
    endtask

    // R6: disabling mid-run stops strobes
    task automatic t_disable();
        @(negedge clk);
        enable_i = 1'b0;
        reload_i = 8'd2;
        trim_i   = 4'd0;
        repeat (2) @(negedge clk);
        enable_i = 1'b1;
        repeat (7) @(negedge clk);
        enable_i = 1'b0;
        @(posedge clk);
        for (int k = 0; k < 20; k++) begin
            @(posedge clk);
            #1;
            chk(!sample_tick && !bit_tick, "R6", int'({sample_tick, bit_tick}), 0);
        end
    endtask

    // R7: reload change mid-slot applies from the next reload
    task automatic t_reload_change();
        int t, prev, n;
        @(negedge clk);
        enable_i = 1'b0;
        reload_i = 8'd9;
        trim_i   = 4'd0;
        repeat (3) @(negedge clk);
        enable_i = 1'b1;
        t = 0; prev = 0; n = 0;
        while (n < 3 && t < 200) begin
            @(posedge clk);
            #1;
            t++;
            if (sample_tick) begin
                if (n == 1) chk(t - prev == 10, "R7", t - prev, 10);
                if (n == 2) chk(t - prev == 4, "R7", t - prev, 4);
                prev = t;
                n++;
            end
            if (n == 1 && t == prev + 3) begin
                @(negedge clk);
                reload_i = 8'd3;
            end
        end
        chk(n == 3, "R7", n, 3);
    endtask

    initial begin
        t_reset();
        t_pattern(4, 0, "R2");
        t_pattern(6, 5, "R3");
        t_pattern(3, 15, "R3");
        t_pattern(0, 0, "R8");
        t_pattern(0, 1, "R3");
        t_disable();
        t_pattern(2, 3, "R3");
        t_reload_change();
        t_pattern(255, 15, "R9");
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000 && !done) begin
                done = 1'b1;
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

endmodule